// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Common-I/O SRAM

This block is a synchronous static memory with a shared data bus that moves two data beats for every command. A command is made of a load strobe, a read/write select and an address, all sampled on a command edge. Every read or write then moves a pair of words: the first beat goes to the word named by the command, and the second goes to its partner word, which differs only in the lowest address bit. The double-data-rate bus is modelled on one clock running at twice the command rate. A phase output tells the two halves apart: phase 0 edges carry commands and first beats, and phase 1 edges carry second beats.

Writes are late: the two data beats, each with its own active-low lane enables, arrive after the command. They are held in a pending write stage and reach the array only when the next write is loaded. Reads are pipelined. A read always returns the newest data, because it merges any pending write lane by lane over the array contents. The bus is modelled as separate data-in and data-out ports with an output enable. Read data and write data sit at the same offset from their command, so commands of any kind can follow each other on consecutive command edges without the two directions overlapping.

With a data width of 18 or 36 the address's lowest bit picks the starting word of the pair, and a one-bit counter flips it for the second beat. With a width of 8 the lanes are 4-bit nybbles and the burst always starts at the even word. In that case the external address selects only the word pair, so it is one bit narrower than the array depth.

Top module: `ddr_cio_sram`

## Requirements
- R1: Every read drives exactly two beats, on two consecutive clock cycles. `dout_oe` changes only on edges that leave `beat_ph` at 1.
- R2: For widths 18 and 36, beat 0 carries the word at `addr` and beat 1 carries the word at `addr` with bit 0 inverted, for both even and odd starting addresses.
- R3: For width 8, `addr` selects a word pair. Beat 0 always uses the even word of that pair (array index `{addr,0}`) and beat 1 the odd word (`{addr,1}`).
- R4: A command is taken only when `ld_n` is 0 at a rising edge where `beat_ph` is 0. With `ld_n` at 1, or at an edge where `beat_ph` is 1, nothing is read or written.
- R5: `rd_wr` = 1 selects a read and `rd_wr` = 0 selects a write.
- R6: `be_n[i]` = 0 enables lane i during a write beat. For widths 18 and 36 a lane is 9 bits (lane 0 = data bits 0..8, lane 1 = bits 9..17, and so on). For width 8 a lane is a 4-bit nybble (lane 0 = bits 0..3, lane 1 = bits 4..7). Each beat uses the `be_n` value sampled together with it.
- R7: Write beat 0 (`din`, `be_n`) is sampled at the second rising edge after the command edge, and beat 1 at the third.
- R8: Read beat 0 appears on `dout` after the second rising edge after the command edge, and beat 1 after the third. `dout_oe` is 1 exactly while read beats are on `dout`.
- R9: A read issued on any command edge after a write command returns that write's data, merged lane by lane, even while the write is still pending and has not yet reached the array.
- R10: Lanes whose enable is 1 during a write beat keep their previous contents.
- R11: While reset is active, `dout_oe` and `beat_ph` are 0. After reset, `beat_ph` toggles on every rising edge.
- R12: Reads and writes may follow each other on consecutive command edges in any order. Each read returns the correct data, and the read beat windows never overlap the write beat windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; two edges per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low command strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Command address |
| be_n | input | WIDTH/lane width | Active-low lane enables, sampled with each write beat |
| din | input | WIDTH | Write data beat |
| dout | output | WIDTH | Read data beat |
| dout_oe | output | 1 | High while a read beat is driven |
| beat_ph | output | 1 | Half-cycle phase: 0 = command / first beat edge next |

## Verification
The main checks are an exhaustive write-then-read sweep over all 32 addresses of an 18-bit configuration. Running it through both even and odd starting addresses tells a counter that flips the start bit apart from one that always starts at the even word. An 8-bit copy of the block, driven by the same stimulus, sees a start bit that must always be forced to the even word. All sixteen combinations of lane enables over the two beats are written and then read in the very next command cycle. This separates correct per-beat masking and forwarding from the pending stage from a merge that uses the wrong beat's mask or that only works after the data has been committed. Mixed orderings follow: write then read, read then write, two writes then a read of the first, and strobes on the wrong phase. These separate a correct commit on the next write, and correct phase gating, from data lost or taken on the wrong edge.

// File: rtl/ddr_cio_sram_pkg.sv
package ddr_cio_sram_pkg;

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } beat_phase_e;

   // Lane size: nybbles for the narrow variant, 9-bit bytes otherwise.
   function automatic int lane_bits(input int width);
      return (width == 8) ? 4 : 9;
   endfunction

   function automatic int lane_count(input int width);
      return width / lane_bits(width);
   endfunction

   // Bits of the external address that select a word pair.
   function automatic int pair_bits(input int width, input int addr_w);
      return (width == 8) ? addr_w : addr_w - 1;
   endfunction

endpackage

// File: rtl/ddr_cio_addr_split.sv
module ddr_cio_addr_split #(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 5,
   parameter int PAIR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [PAIR_W-1:0] pair,
   output logic              start
);

   generate
      if (WIDTH == 8) begin : g_fixed_start
         // Narrow variant: the whole address picks the pair, start is even.
         assign pair  = addr;
         assign start = 1'b0;
      end else begin : g_preset_start
         // Wide variant: bit 0 presets the one-bit burst counter.
         assign pair  = addr[ADDR_W-1:1];
         assign start = addr[0];
      end
   endgenerate

endmodule

// File: rtl/ddr_cio_cmd_pipe.sv
module ddr_cio_cmd_pipe
   import ddr_cio_sram_pkg::*;
#(
   parameter int PAIR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rd_wr,
   input  logic [PAIR_W-1:0] cmd_pair,
   input  logic              cmd_start,
   output logic              phase,
   output logic              rd_fetch,
   output logic [PAIR_W-1:0] rd_pair,
   output logic              rd_slot,
   output logic              wr_load,
   output logic              wr_fill,
   output logic [PAIR_W-1:0] wr_pair,
   output logic              wr_start
);

   beat_phase_e       ph_q;
   logic              accept;
   // read command stage (beat 0 pending) and read output stage (beat 1)
   logic              rc_v_q, ro_v_q;
   logic [PAIR_W-1:0] rc_pair_q, ro_pair_q;
   logic              rc_start_q, ro_start_q;
   // write address stage and second-beat flag
   logic              ws_v_q, fill_q;
   logic [PAIR_W-1:0] ws_pair_q;
   logic              ws_start_q;

   assign accept = (ph_q == PH_EVEN) && !ld_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_EVEN;
         rc_v_q     <= 1'b0;
         rc_pair_q  <= '0;
         rc_start_q <= 1'b0;
         ro_v_q     <= 1'b0;
         ro_pair_q  <= '0;
         ro_start_q <= 1'b0;
         ws_v_q     <= 1'b0;
         ws_pair_q  <= '0;
         ws_start_q <= 1'b0;
         fill_q     <= 1'b0;
      end else begin
         ph_q <= (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
         if (ph_q == PH_EVEN) begin
            rc_v_q     <= accept && rd_wr;
            rc_pair_q  <= cmd_pair;
            rc_start_q <= cmd_start;
            ro_v_q     <= rc_v_q;
            ro_pair_q  <= rc_pair_q;
            ro_start_q <= rc_start_q;
            ws_v_q     <= accept && !rd_wr;
            ws_pair_q  <= cmd_pair;
            ws_start_q <= cmd_start;
            fill_q     <= ws_v_q;
         end else begin
            fill_q <= 1'b0;
         end
      end
   end

   assign phase    = (ph_q == PH_ODD);
   assign rd_fetch = phase ? ro_v_q : rc_v_q;
   assign rd_pair  = phase ? ro_pair_q : rc_pair_q;
   assign rd_slot  = phase ? ~ro_start_q : rc_start_q;
   assign wr_load  = !phase && ws_v_q;
   assign wr_fill  = phase && fill_q;
   assign wr_pair  = ws_pair_q;
   assign wr_start = ws_start_q;

endmodule

// File: rtl/ddr_cio_late_wbuf.sv
module ddr_cio_late_wbuf #(
   parameter int WIDTH  = 18,
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int PAIR_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_load,
   input  logic                        wr_fill,
   input  logic [PAIR_W-1:0]           wr_pair,
   input  logic                        wr_start,
   input  logic [WIDTH-1:0]            din,
   input  logic [LANES-1:0]            be_n,
   input  logic [PAIR_W-1:0]           rd_pair,
   input  logic                        rd_slot,
   input  logic [WIDTH-1:0]            rd_base,
   output logic [WIDTH-1:0]            rd_merged,
   output logic                        commit,
   output logic [PAIR_W-1:0]           commit_pair,
   output logic [1:0][WIDTH-1:0]       commit_data,
   output logic [1:0][LANES-1:0]       commit_mask
);

   logic                  pv_q;
   logic [PAIR_W-1:0]     pair_q;
   logic                  start_q;
   logic [1:0][WIDTH-1:0] data_q;
   logic [1:0][LANES-1:0] mask_q;
   logic                  hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q    <= 1'b0;
         pair_q  <= '0;
         start_q <= 1'b0;
         data_q  <= '0;
         mask_q  <= '0;
      end else if (wr_load) begin
         // the previous pending write leaves through commit on this edge
         pv_q              <= 1'b1;
         pair_q            <= wr_pair;
         start_q           <= wr_start;
         data_q[wr_start]  <= din;
         mask_q[wr_start]  <= ~be_n;
         mask_q[~wr_start] <= '0;
      end else if (wr_fill) begin
         data_q[~start_q] <= din;
         mask_q[~start_q] <= ~be_n;
      end
   end

   assign commit      = wr_load && pv_q;
   assign commit_pair = pair_q;
   assign commit_data = data_q;
   assign commit_mask = mask_q;

   assign hit = pv_q && (pair_q == rd_pair);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_fwd
         assign rd_merged[l*LANE_W +: LANE_W] =
            (hit && mask_q[rd_slot][l]) ? data_q[rd_slot][l*LANE_W +: LANE_W]
                                        : rd_base[l*LANE_W +: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/ddr_cio_array.sv
module ddr_cio_array #(
   parameter int WIDTH  = 18,
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int PAIR_W = 4
) (
   input  logic                  clk,
   input  logic                  commit,
   input  logic [PAIR_W-1:0]     commit_pair,
   input  logic [1:0][WIDTH-1:0] commit_data,
   input  logic [1:0][LANES-1:0] commit_mask,
   input  logic [PAIR_W-1:0]     rd_pair,
   input  logic                  rd_slot,
   output logic [WIDTH-1:0]      rd_data
);

   localparam int WORDS = 2 ** (PAIR_W + 1);

   logic [WIDTH-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (commit) begin
         for (int s = 0; s < 2; s++) begin
            for (int l = 0; l < LANES; l++) begin
               if (commit_mask[s][l]) begin
                  mem_q[{commit_pair, 1'(s)}][l*LANE_W +: LANE_W] <=
                     commit_data[s][l*LANE_W +: LANE_W];
               end
            end
         end
      end
   end

   assign rd_data = mem_q[{rd_pair, rd_slot}];

endmodule

// File: rtl/ddr_cio_sram.sv
module ddr_cio_sram
   import ddr_cio_sram_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_n,
   input  logic                          rd_wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [lane_count(WIDTH)-1:0]  be_n,
   input  logic [WIDTH-1:0]              din,
   output logic [WIDTH-1:0]              dout,
   output logic                          dout_oe,
   output logic                          beat_ph
);

   localparam int LANE_W = lane_bits(WIDTH);
   localparam int LANES  = lane_count(WIDTH);
   localparam int PAIR_W = pair_bits(WIDTH, ADDR_W);

   generate
      if (!(WIDTH == 8 || WIDTH == 18 || WIDTH == 36)) begin : g_bad_width
         $error("ddr_cio_sram: WIDTH must be 8, 18 or 36");
      end
      if (ADDR_W < 2 || ADDR_W > 11) begin : g_bad_addr
         $error("ddr_cio_sram: ADDR_W must lie in 2..11");
      end
   endgenerate

   logic [PAIR_W-1:0]     cmd_pair, rd_pair, wr_pair, commit_pair;
   logic                  cmd_start, rd_slot, wr_start;
   logic                  rd_fetch, wr_load, wr_fill, commit;
   logic [1:0][WIDTH-1:0] commit_data;
   logic [1:0][LANES-1:0] commit_mask;
   logic [WIDTH-1:0]      arr_data, merged;
   logic [WIDTH-1:0]      dout_q;
   logic                  oe_q;

   ddr_cio_addr_split #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .PAIR_W(PAIR_W)) u_split (
      .addr  (addr),
      .pair  (cmd_pair),
      .start (cmd_start)
   );

   ddr_cio_cmd_pipe #(.PAIR_W(PAIR_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_n      (ld_n),
      .rd_wr     (rd_wr),
      .cmd_pair  (cmd_pair),
      .cmd_start (cmd_start),
      .phase     (beat_ph),
      .rd_fetch  (rd_fetch),
      .rd_pair   (rd_pair),
      .rd_slot   (rd_slot),
      .wr_load   (wr_load),
      .wr_fill   (wr_fill),
      .wr_pair   (wr_pair),
      .wr_start  (wr_start)
   );

   ddr_cio_late_wbuf #(.WIDTH(WIDTH), .LANE_W(LANE_W), .LANES(LANES), .PAIR_W(PAIR_W)) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_load     (wr_load),
      .wr_fill     (wr_fill),
      .wr_pair     (wr_pair),
      .wr_start    (wr_start),
      .din         (din),
      .be_n        (be_n),
      .rd_pair     (rd_pair),
      .rd_slot     (rd_slot),
      .rd_base     (arr_data),
      .rd_merged   (merged),
      .commit      (commit),
      .commit_pair (commit_pair),
      .commit_data (commit_data),
      .commit_mask (commit_mask)
   );

   ddr_cio_array #(.WIDTH(WIDTH), .LANE_W(LANE_W), .LANES(LANES), .PAIR_W(PAIR_W)) u_array (
      .clk         (clk),
      .commit      (commit),
      .commit_pair (commit_pair),
      .commit_data (commit_data),
      .commit_mask (commit_mask),
      .rd_pair     (rd_pair),
      .rd_slot     (rd_slot),
      .rd_data     (arr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         oe_q <= rd_fetch;
         if (rd_fetch) begin
            dout_q <= merged;
         end
      end
   end

   assign dout    = dout_q;
   assign dout_oe = oe_q;

endmodule

// File: rtl/ddr_cio_sram_chk.sv
module ddr_cio_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic ld_n,
   input logic rd_wr,
   input logic dout_oe,
   input logic beat_ph
);

   // R8: a read command yields output enable on the 2nd and 3rd edges after it
   p_read_window_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_ph && !ld_n && rd_wr) |-> ##3 dout_oe ##1 dout_oe);

   // R4: no read accepted means no driven beats in that command's window
   p_idle_no_oe_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_ph && (ld_n || !rd_wr)) |-> ##3 !dout_oe ##1 !dout_oe);

   // R1: the enable only changes on edges that leave the phase at 1
   p_oe_change_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_oe) |-> beat_ph);

   // R11: phase alternates on every edge
   p_phase_rise_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !beat_ph |=> beat_ph);

   p_phase_fall_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      beat_ph |=> !beat_ph);

endmodule

bind ddr_cio_sram ddr_cio_sram_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_n    (ld_n),
   .rd_wr   (rd_wr),
   .dout_oe (dout_oe),
   .beat_ph (beat_ph)
);

// File: tb/ddr_cio_sram_bench.sv
`timescale 1ns/1ps
module ddr_cio_sram_bench;

   localparam int W  = 18;
   localparam int AW = 5;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n  = 1'b1;
   logic          rd_wr = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic [1:0]    be_n  = 2'b11;
   logic [W-1:0]  din   = '0;
   logic [W-1:0]  dout;
   logic          oe, ph;
   logic [7:0]    dout8;
   logic          oe8, ph8;

   always #2 clk = ~clk;

   ddr_cio_sram #(.WIDTH(18), .ADDR_W(5)) u_ddr_cio_sram (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
      .be_n(be_n), .din(din), .dout(dout), .dout_oe(oe), .beat_ph(ph));

   ddr_cio_sram #(.WIDTH(8), .ADDR_W(4)) u_ddr_cio_sram_x8 (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr[3:0]),
      .be_n(be_n), .din(din[7:0]), .dout(dout8), .dout_oe(oe8), .beat_ph(ph8));

   logic [W-1:0] m18 [32];
   logic [7:0]   m8  [32];
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // pipeline of outstanding expectations
   bit           r1_v = 1'b0, r2_v = 1'b0, w1_v = 1'b0;
   logic [W-1:0] r1_e0, r1_e1, r2_e1;
   logic [7:0]   r1_f0, r1_f1, r2_f1;
   logic [W-1:0] w1_d0, w1_d1;
   logic [1:0]   w1_b0, w1_b1;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] mrg18(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [1:0] bn);
      logic [W-1:0] r = old;
      if (!bn[0]) r[8:0]  = nw[8:0];
      if (!bn[1]) r[17:9] = nw[17:9];
      return r;
   endfunction

   function automatic logic [7:0] mrg8(input logic [7:0] old, input logic [7:0] nw,
                                       input logic [1:0] bn);
      logic [7:0] r = old;
      if (!bn[0]) r[3:0] = nw[3:0];
      if (!bn[1]) r[7:4] = nw[7:4];
      return r;
   endfunction

   function automatic logic [W-1:0] pat(input int a, input int b, input int r);
      return W'((a * 2731 + b * 1187 + r * 613 + 91) * 7);
   endfunction

   // One command cycle: two clock periods, starting at a negedge with phase 0.
   task automatic slot(input bit v, input bit rd, input int a, input logic [W-1:0] d0,
                       input logic [W-1:0] d1, input logic [1:0] b0, input logic [1:0] b1,
                       input bit rogue);
      logic [AW-1:0] aa = AW'(a);
      bit            c_v = v && rd;
      logic [W-1:0]  ce0 = '0, ce1 = '0;
      logic [7:0]    cf0 = '0, cf1 = '0;
      // first half: previous read beat 1, new command, write beat 0
      chk(ph === 1'b0, "R11 phase at command edge", W'(ph), '0);
      chk(oe === r2_v, "R8 oe during beat 1", W'(oe), W'(r2_v));
      chk(oe8 === r2_v, "R8 x8 oe during beat 1", W'(oe8), W'(r2_v));
      if (r2_v) begin
         chk(dout === r2_e1, "R2 R9 R12 beat 1 data", dout, r2_e1);
         chk(dout8 === r2_f1, "R3 x8 beat 1 data", W'(dout8), W'(r2_f1));
      end
      ld_n  = !v;
      rd_wr = rd;
      addr  = aa;
      din   = w1_v ? w1_d0 : '0;
      be_n  = w1_v ? w1_b0 : 2'b11;
      if (v && rd) begin
         ce0 = m18[aa];
         ce1 = m18[aa ^ 5'd1];
         cf0 = m8[{aa[3:0], 1'b0}];
         cf1 = m8[{aa[3:0], 1'b1}];
      end else if (v) begin
         m18[aa]         = mrg18(m18[aa], d0, b0);
         m18[aa ^ 5'd1]  = mrg18(m18[aa ^ 5'd1], d1, b1);
         m8[{aa[3:0], 1'b0}] = mrg8(m8[{aa[3:0], 1'b0}], d0[7:0], b0);
         m8[{aa[3:0], 1'b1}] = mrg8(m8[{aa[3:0], 1'b1}], d1[7:0], b1);
      end
      @(posedge clk);
      @(negedge clk);
      // second half: read beat 0 of previous command, write beat 1
      chk(oe === r1_v, "R8 oe during beat 0", W'(oe), W'(r1_v));
      chk(oe8 === r1_v, "R8 x8 oe during beat 0", W'(oe8), W'(r1_v));
      if (r1_v) begin
         chk(dout === r1_e0, "R2 R9 R12 beat 0 data", dout, r1_e0);
         chk(dout8 === r1_f0, "R3 x8 beat 0 data", W'(dout8), W'(r1_f0));
      end
      din   = w1_v ? w1_d1 : '0;
      be_n  = w1_v ? w1_b1 : 2'b11;
      ld_n  = !rogue;     // R4: strobe on a phase 1 edge must be ignored
      rd_wr = rogue ? 1'b1 : rd_wr;
      r2_v  = r1_v;  r2_e1 = r1_e1; r2_f1 = r1_f1;
      r1_v  = c_v;   r1_e0 = ce0;   r1_e1 = ce1;  r1_f0 = cf0; r1_f1 = cf1;
      w1_v  = v && !rd;
      w1_d0 = d0;    w1_d1 = d1;    w1_b0 = b0;   w1_b1 = b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                     input logic [1:0] b0, input logic [1:0] b1);
      slot(1'b1, 1'b0, a, d0, d1, b0, b1, 1'b0);
   endtask

   task automatic rd(input int a);
      slot(1'b1, 1'b1, a, '0, '0, 2'b11, 2'b11, 1'b0);
   endtask

   task automatic idle(input bit rogue);
      slot(1'b0, 1'b0, 0, '0, '0, 2'b11, 2'b11, rogue);
   endtask

   initial begin
      int alist [4] = '{3, 10, 17, 30};
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(oe === 1'b0, "R11 oe in reset", W'(oe), '0);
      chk(ph === 1'b0, "R11 phase in reset", W'(ph), '0);
      chk(oe8 === 1'b0, "R11 x8 oe in reset", W'(oe8), '0);
      rst_n = 1'b1;
      // R5 R7: fill every word with full-lane writes, back to back
      for (int a = 0; a < 32; a++) wr(a, pat(a, 0, 0), pat(a, 1, 0), 2'b00, 2'b00);
      // R2 R3: read every address, even and odd starts
      for (int a = 0; a < 32; a++) rd(a);
      // R6 R9 R10: every lane mask pair, read in the very next command cycle
      foreach (alist[i]) begin
         for (int m = 0; m < 16; m++) begin
            wr(alist[i], pat(alist[i], 0, m + 1), pat(alist[i], 1, m + 1),
               2'(m), 2'(m >> 2));
            rd(alist[i]);
         end
      end
      // R12: mixed orderings; R4: idle with phase-1 strobes
      wr(5, pat(5, 0, 40), pat(5, 1, 40), 2'b00, 2'b10);
      rd(5);
      rd(4);
      wr(4, pat(4, 0, 41), pat(4, 1, 41), 2'b01, 2'b00);
      rd(4);
      wr(20, pat(20, 0, 42), pat(20, 1, 42), 2'b00, 2'b00);
      wr(21, pat(21, 0, 43), pat(21, 1, 43), 2'b10, 2'b01);
      rd(20);
      rd(21);
      idle(1'b1);
      idle(1'b1);
      rd(7);
      wr(7, pat(7, 0, 44), pat(7, 1, 44), 2'b11, 2'b11);   // R10 all lanes held
      rd(6);
      idle(1'b0);
      rd(7);
      // R9: everything again after the pending writes have been committed
      for (int a = 0; a < 32; a++) rd(a);
      idle(1'b0);
      idle(1'b0);
      idle(1'b0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule